// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Controller

This block holds the status and interrupt logic of a serial peripheral interface. A host reaches it through a small register bus: a control register, a pin-direction register, a status register and a receive data register. The shift engine outside the block reports each finished byte with a one-cycle strobe and the byte. The block then latches the byte into the data register and raises a transfer-complete flag.

When the block is enabled as master and slave-select fault detection is on, a low level on the slave-select input is a mode fault. The fault sets a second flag and forces the enable, master and pin-direction bits to zero, so the port stops driving the bus. Both flags share one interrupt line, gated by an interrupt-enable bit. Each flag clears only through a two-step sequence. First the status register is read while the flag is set. Then a flag-specific register access completes the clear.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset every register reads zero: control (address 0), direction (address 1), status (address 2) and data (address 3). The interrupt output is low.
- R2: A byte strobe that arrives while the transfer-complete flag (status bit 0) is clear loads the byte into the data register and sets that flag on the same clock edge.
- R3: A byte strobe that arrives while the transfer-complete flag is set is dropped, unless that cycle completes the flag's clear sequence. The data register keeps the earlier byte.
- R4: The transfer-complete flag clears only on a read or write of the data register that follows a status read which saw the flag set. A data access with no such prior status read leaves the flag at 1.
- R5: A status read that sees a flag set arms that flag's clear. The arm stays in place across unrelated bus accesses until the qualifying access uses it.
- R6: The mode-fault flag (status bit 1) is set when slave-select is low while the enable bit (control bit 0), the master bit (control bit 1) and the fault-detect bit (control bit 3) are all 1. With either the master bit or the fault-detect bit at 0, a low slave-select has no effect.
- R7: A mode fault forces the enable bit, the master bit and the 3-bit direction field (address 1, bits 2:0) to zero on the edge that sets the flag. The interrupt-enable and fault-detect bits are kept.
- R8: The mode-fault flag clears only on a control-register write that follows a status read which saw the flag set. Data accesses do not clear it, and neither does a control write with no such read before it.
- R9: The interrupt output is high exactly when the interrupt-enable bit (control bit 2) is 1 and at least one flag is set.
- R10: When a set condition and a completing clear access fall in the same cycle, the flag stays at 1. For the transfer-complete flag the new byte is also loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational, zero when idle) |
| rx_done_i | input | 1 | One-cycle strobe: a received byte is complete |
| rx_byte_i | input | 8 | Received byte |
| ss_ni | input | 1 | Slave-select input, active low |
| spe_o | output | 1 | Port enable |
| mstr_o | output | 1 | Master mode |
| pin_dir_o | output | 3 | Pin-direction field |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench checks the ordering of each clear sequence. A data or control access made without an armed status read must leave the flag set. A design that cleared on access alone would drop the flag too early. It also places unrelated accesses between the arming read and the completing access, which catches an arm that expires after one cycle. A byte strobe lands in the same cycle as the completing data read. A design that let the clear win would lose the new byte and its flag. Mode faults are driven with the master bit or the fault-detect bit clear to catch a missing gating term. The bench then checks that a real fault clears only the enable, master and direction bits.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DIR  = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_addr_e;

  localparam int CTRL_SPE  = 0;
  localparam int CTRL_MSTR = 1;
  localparam int CTRL_IE   = 2;
  localparam int CTRL_FEN  = 3;

  localparam int FLAG_XFER  = 0;
  localparam int FLAG_FAULT = 1;
  localparam int NFLAG      = 2;
endpackage

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs #(
  parameter int DW    = 8,
  parameter int DIR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             dir_we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             fault_set_i,
  output logic             spe_o,
  output logic             mstr_o,
  output logic             ie_o,
  output logic             fen_o,
  output logic [DIR_W-1:0] dir_o
);
  import spi_flag_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spe_o  <= 1'b0;
      mstr_o <= 1'b0;
      ie_o   <= 1'b0;
      fen_o  <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        spe_o  <= wdata_i[CTRL_SPE];
        mstr_o <= wdata_i[CTRL_MSTR];
        ie_o   <= wdata_i[CTRL_IE];
        fen_o  <= wdata_i[CTRL_FEN];
      end
      // fault overrides any same-cycle write
      if (fault_set_i) begin
        spe_o  <= 1'b0;
        mstr_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          dir_o <= '0;
    else if (fault_set_i) dir_o <= '0;
    else if (dir_we_i)    dir_o <= wdata_i[DIR_W-1:0];
  end
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic clr_acc_i,
  output logic flag_o,
  output logic clr_fire_o
);
  logic arm_q;

  assign clr_fire_o = arm_q & clr_acc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)           flag_o <= 1'b1;
      else if (clr_fire_o) flag_o <= 1'b0;

      if (clr_fire_o)                arm_q <= 1'b0;
      else if (stat_rd_i && flag_o)  arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (load_i) data_o <= byte_i;
  end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl #(
  parameter int DW    = 8,
  parameter int AW    = 2,
  parameter int DIR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic             rx_done_i,
  input  logic [DW-1:0]    rx_byte_i,
  input  logic             ss_ni,
  output logic             spe_o,
  output logic             mstr_o,
  output logic [DIR_W-1:0] pin_dir_o,
  output logic             irq_o
);
  import spi_flag_pkg::*;

  logic ctrl_wr, dir_wr, stat_rd, data_acc;
  logic ie_q, fen_q, fault_set, rx_load;
  logic [NFLAG-1:0] flag_q, flag_set, flag_clr, clr_fire;
  logic [DW-1:0] data_q;

  assign ctrl_wr  = bus_sel_i &  bus_we_i & (bus_addr_i == AW'(REG_CTRL));
  assign dir_wr   = bus_sel_i &  bus_we_i & (bus_addr_i == AW'(REG_DIR));
  assign stat_rd  = bus_sel_i & ~bus_we_i & (bus_addr_i == AW'(REG_STAT));
  assign data_acc = bus_sel_i &             (bus_addr_i == AW'(REG_DATA));

  assign fault_set = spe_o & mstr_o & fen_q & ~ss_ni;
  // a byte is accepted when the slot is free or is being freed this cycle
  assign rx_load   = rx_done_i & (~flag_q[FLAG_XFER] | clr_fire[FLAG_XFER]);

  assign flag_set[FLAG_XFER]  = rx_load;
  assign flag_set[FLAG_FAULT] = fault_set;
  assign flag_clr[FLAG_XFER]  = data_acc;
  assign flag_clr[FLAG_FAULT] = ctrl_wr;

  spi_ctrl_regs #(.DW(DW), .DIR_W(DIR_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_wr),
    .dir_we_i    (dir_wr),
    .wdata_i     (bus_wdata_i),
    .fault_set_i (fault_set),
    .spe_o       (spe_o),
    .mstr_o      (mstr_o),
    .ie_o        (ie_q),
    .fen_o       (fen_q),
    .dir_o       (pin_dir_o)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    spi_flag_unit i_flag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (flag_set[g]),
      .stat_rd_i  (stat_rd),
      .clr_acc_i  (flag_clr[g]),
      .flag_o     (flag_q[g]),
      .clr_fire_o (clr_fire[g])
    );
  end

  spi_rx_hold #(.DW(DW)) i_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rx_load),
    .byte_i (rx_byte_i),
    .data_o (data_q)
  );

  assign irq_o = ie_q & (|flag_q);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      unique case (bus_addr_i)
        AW'(REG_CTRL): begin
          bus_rdata_o[CTRL_SPE]  = spe_o;
          bus_rdata_o[CTRL_MSTR] = mstr_o;
          bus_rdata_o[CTRL_IE]   = ie_q;
          bus_rdata_o[CTRL_FEN]  = fen_q;
        end
        AW'(REG_DIR):  bus_rdata_o[DIR_W-1:0] = pin_dir_o;
        AW'(REG_STAT): bus_rdata_o[NFLAG-1:0] = flag_q;
        default:       bus_rdata_o = data_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk #(
  parameter int DW    = 8,
  parameter int AW    = 2,
  parameter int DIR_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_sel_i,
  input logic             bus_we_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic             rx_done_i,
  input logic             ss_ni,
  input logic             spe_o,
  input logic             mstr_o,
  input logic [DIR_W-1:0] pin_dir_o,
  input logic             irq_o,
  input logic             ie_q,
  input logic             fen_q,
  input logic [1:0]       flag_q,
  input logic [DW-1:0]    data_q
);
  logic data_acc, ctrl_wr;
  assign data_acc = bus_sel_i && (bus_addr_i == AW'(3));
  assign ctrl_wr  = bus_sel_i && bus_we_i && (bus_addr_i == AW'(0));

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && !flag_q[0]) |=> flag_q[0]);

  p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && flag_q[0] && !data_acc) |=> $stable(data_q));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[0] && !data_acc) |=> flag_q[0]);

  p_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spe_o && mstr_o && fen_q && !ss_ni) |=> flag_q[1]);

  p_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spe_o && mstr_o && fen_q && !ss_ni) |=> (!spe_o && !mstr_o && pin_dir_o == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[1] && !ctrl_wr) |=> flag_q[1]);

  p_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_q |-> !irq_o);

  p_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q && flag_q != 2'b00) |-> irq_o);
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk #(.DW(DW), .AW(AW), .DIR_W(DIR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_sel_i  (bus_sel_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .rx_done_i  (rx_done_i),
  .ss_ni      (ss_ni),
  .spe_o      (spe_o),
  .mstr_o     (mstr_o),
  .pin_dir_o  (pin_dir_o),
  .irq_o      (irq_o),
  .ie_q       (ie_q),
  .fen_q      (fen_q),
  .flag_q     (flag_q),
  .data_q     (data_q)
);

// File: tb/test_spi_flag_ctrl.sv
module test_spi_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       rx_done = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       ss_n = 1'b1;
  logic       spe, mstr, irq;
  logic [2:0] dir;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { string req; logic [7:0] exp; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  spi_flag_ctrl i_spi_flag_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_done_i(rx_done), .rx_byte_i(rx_byte), .ss_ni(ss_n),
    .spe_o(spe), .mstr_o(mstr), .pin_dir_o(dir), .irq_o(irq));

  // monitor: compares each read against the scoreboard head
  always begin
    @(negedge clk); #2;
    if (sel && !we) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected read addr %0d got %02h exp none", addr, rdata);
      end else begin
        e = sb.pop_front();
        if (rdata !== e.exp) begin
          errors++;
          $display("FAIL %s addr %0d got %02h exp %02h", e.req, addr, rdata, e.exp);
        end
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", req, act, exp);
    end
  endtask

  task automatic op(bit w, logic [1:0] a, logic [7:0] d, string req = "",
                    bit with_rx = 0, logic [7:0] b = '0);
    @(negedge clk);
    if (!w) sb.push_back('{req, d});
    sel = 1; we = w; addr = a; wdata = w ? d : 8'h00;
    if (with_rx) begin rx_done = 1; rx_byte = b; end
    @(posedge clk); #1;
    sel = 0; we = 0; rx_done = 0;
  endtask

  task automatic rx(logic [7:0] b);
    @(negedge clk);
    rx_done = 1; rx_byte = b;
    @(posedge clk); #1;
    rx_done = 0;
  endtask

  task automatic ss_pulse();
    @(negedge clk); ss_n = 0;
    @(posedge clk); #1; ss_n = 1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset values
    chk("R1 irq", {7'b0, irq}, 8'h00);
    op(0, 0, 8'h00, "R1 ctrl");
    op(0, 1, 8'h00, "R1 dir");
    op(0, 2, 8'h00, "R1 stat");
    op(0, 3, 8'h00, "R1 data");

    // R2 load, R3 drop while set, R4 ordered clear
    rx(8'hA5);
    rx(8'h3C);
    op(0, 2, 8'h01, "R2 stat");
    op(0, 3, 8'hA5, "R3 data kept");
    op(0, 2, 8'h00, "R4 cleared");

    // R4 unarmed access, R5 arm survives other accesses
    rx(8'h11);
    op(0, 3, 8'h11, "R4 data");
    op(0, 2, 8'h01, "R4 unarmed no clear");
    op(1, 0, 8'h00);
    op(0, 1, 8'h00, "R5 dir");
    op(1, 1, 8'h05);
    op(1, 3, 8'h77);
    op(0, 2, 8'h00, "R5 arm kept");
    op(0, 1, 8'h05, "R5 dir written");

    // R9 interrupt gating
    op(1, 0, 8'h04);
    chk("R9 idle irq", {7'b0, irq}, 8'h00);
    rx(8'h22);
    chk("R9 irq xfer", {7'b0, irq}, 8'h01);
    op(0, 2, 8'h01, "R9 stat");
    op(0, 3, 8'h22, "R9 data");
    chk("R9 irq cleared", {7'b0, irq}, 8'h00);

    // R10 set beats clear, new byte loaded
    rx(8'h33);
    op(0, 2, 8'h01, "R10 arm");
    op(0, 3, 8'h33, "R10 data", 1, 8'h44);
    op(0, 2, 8'h01, "R10 flag held");
    op(0, 3, 8'h44, "R10 new byte");
    op(0, 2, 8'h00, "R10 clear");

    // R6 gating: no fault-detect, then no master
    op(1, 0, 8'h07);
    op(1, 1, 8'h07);
    ss_pulse();
    op(0, 2, 8'h00, "R6 fen off");
    op(0, 0, 8'h07, "R6 ctrl kept");
    op(1, 0, 8'h0D);
    ss_pulse();
    op(0, 2, 8'h00, "R6 mstr off");

    // R6/R7 real fault
    op(1, 0, 8'h0F);
    ss_pulse();
    chk("R7 spe", {7'b0, spe}, 8'h00);
    chk("R7 mstr", {7'b0, mstr}, 8'h00);
    chk("R7 dir", {5'b0, dir}, 8'h00);
    chk("R9 irq fault", {7'b0, irq}, 8'h01);
    op(0, 0, 8'h0C, "R7 ctrl");

    // R8 ordered clear
    op(1, 0, 8'h0C);
    chk("R8 unarmed write keeps", {7'b0, irq}, 8'h01);
    op(0, 2, 8'h02, "R8 stat");
    op(0, 3, 8'h44, "R8 data");
    op(0, 2, 8'h02, "R8 data no clear");
    op(1, 0, 8'h04);
    op(0, 2, 8'h00, "R8 cleared");
    chk("R8 irq", {7'b0, irq}, 8'h00);

    repeat (3) @(posedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d got %0d exp 0", sb.size(), sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule